// File: doc/BRIEF.md
# Selectable-Polynomial Block CRC Engine

This block computes a cyclic redundancy check over a block of bytes, one byte per clock, using one of four generator polynomials chosen at run time. Bytes arrive through a valid/ready handshake. Markers flag the first and the last byte of each block. The same engine serves both ends of a link.

As a sender, it leaves the remainder on `crc_out` after the last byte, so the checksum can be appended to the block. As a receiver, it is fed the data followed by the appended check bytes. A block passes when the final remainder is zero, so no stored checksum is compared. The engine only detects errors. It neither corrects nor retransmits.

Division runs most significant bit first, with no bit reflection and no final inversion. The remainder left by each byte seeds the next byte. Each block restarts from a programmable initial value that both ends must share.

Top module: `blk_crc_unit`

## Requirements
- R1: `cfg_poly_sel` picks the generator: 0 = x^4+x+1 (4-bit), 1 = x^8+x^4+x^3+x^2+1 (8-bit), 2 = x^16+x^15+x^2+1 (16-bit), 3 = x^16+x^12+x^5+1 (16-bit). A one-byte block 0x01 from a zero initial value leaves 0x3, 0x1D, 0x8005 and 0x1021 respectively.
- R2: Each accepted byte (`in_valid` and `in_ready` high at a rising edge) is divided into the remainder MSB first. The result appears on `crc_out` after that same edge, so the engine takes one byte per cycle with no stall.
- R3: The remainder chains from byte to byte within a block, and `crc_out` is unchanged in any cycle without an accepted byte.
- R4: After reset `crc_out`, `res_valid` and `res_ok` are 0. An accepted byte with `in_sob` high is processed from `cfg_init` (its low W bits) instead of the running remainder. With initial value I, a block made of the W/8 bytes of I (high byte first) leaves a zero remainder.
- R5: In transmit mode (`cfg_mode_rx` = 0 at block start), the cycle after the `in_eob` byte is accepted shows `res_valid` high for exactly one cycle. `crc_out` then holds the block checksum and `res_ok` is 0.
- R6: In receive mode (`cfg_mode_rx` = 1), the result pulse carries `res_ok` = 1 exactly when the final remainder is zero. The check bytes are appended as follows: 16-bit modes send two bytes, high byte first; the 8-bit mode sends one byte; the 4-bit mode sends one byte with the checksum in bits 7:4 and zeros in bits 3:0. An error-free block then gives `res_ok` = 1, and a single-bit or short burst error gives 0.
- R7: `crc_out` bits at and above the selected width W are always 0.
- R8: `cfg_poly_sel`, `cfg_mode_rx` and `cfg_init` are sampled only on the accepted start-of-block byte. Changing them mid-block has no effect on that block.
- R9: `in_ready` is 0 during reset, rises within four clock edges after `rst_n` is released, and then stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on a clock edge |
| cfg_mode_rx | input | 1 | 0 = transmit (produce checksum), 1 = receive (test for zero residue) |
| cfg_poly_sel | input | 2 | Generator polynomial select |
| cfg_init | input | 16 | Initial remainder loaded at block start (low W bits used) |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| in_data | input | 8 | Data byte, processed MSB first |
| in_sob | input | 1 | Byte is the first of a block |
| in_eob | input | 1 | Byte is the last of a block |
| crc_out | output | 16 | Running remainder, zero-extended |
| res_valid | output | 1 | One-cycle pulse after the last byte of a block |
| res_ok | output | 1 | With res_valid in receive mode: remainder is zero |

## Verification
A corrupted remainder register shows on `crc_out` in the very next cycle, because the port exposes the register directly. The bench compares that value every clock against a model that redivides the whole received block from scratch, so a fault is seen within one cycle of the byte that exposes it. A wrong latched polynomial or mode shows as a wrong remainder on the next byte, or as a wrong `res_ok` on the result pulse. A broken pulse generator shows as a missing or doubled `res_valid`, which is checked in the cycle after every end-of-block byte.

// File: rtl/blk_crc_pkg.sv
package blk_crc_pkg;

  localparam int BYTE_W    = 8;
  localparam int CRC_MAX_W = 16;

  typedef enum logic [1:0] {
    POLY_W4   = 2'd0,
    POLY_W8   = 2'd1,
    POLY_W16A = 2'd2,
    POLY_W16B = 2'd3
  } poly_sel_e;

endpackage

// File: rtl/blk_crc_rst_sync.sv
module blk_crc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/blk_crc_poly_table.sv
module blk_crc_poly_table
  import blk_crc_pkg::*;
#(
  parameter int CRC_W = CRC_MAX_W
) (
  input  poly_sel_e        sel,
  output logic [CRC_W-1:0] taps,
  output logic [CRC_W-1:0] msb_mask,
  output logic [CRC_W-1:0] width_mask
);

  int unsigned deg;

  always_comb begin
    unique case (sel)
      POLY_W4: begin
        deg  = 4;
        taps = CRC_W'(16'h0003);
      end
      POLY_W8: begin
        deg  = 8;
        taps = CRC_W'(16'h001D);
      end
      POLY_W16A: begin
        deg  = 16;
        taps = CRC_W'(16'h8005);
      end
      default: begin
        deg  = 16;
        taps = CRC_W'(16'h1021);
      end
    endcase
    width_mask = CRC_W'((33'd1 << deg) - 33'd1);
    msb_mask   = CRC_W'(33'd1 << (deg - 1));
  end

endmodule

// File: rtl/blk_crc_byte_step.sv
module blk_crc_byte_step #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16
) (
  input  logic [CRC_W-1:0]  rem_in,
  input  logic [DATA_W-1:0] data,
  input  logic [CRC_W-1:0]  taps,
  input  logic [CRC_W-1:0]  msb_mask,
  input  logic [CRC_W-1:0]  width_mask,
  output logic [CRC_W-1:0]  rem_out
);

  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = rem_in & width_mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic fb;
    assign fb = (|(chain[g] & msb_mask)) ^ data[DATA_W-1-g];
    assign chain[g+1] = ((chain[g] << 1) & width_mask) ^ (taps & {CRC_W{fb}});
  end

  assign rem_out = chain[DATA_W];

endmodule

// File: rtl/blk_crc_unit.sv
module blk_crc_unit
  import blk_crc_pkg::*;
#(
  parameter int DATA_W      = BYTE_W,
  parameter int CRC_W       = CRC_MAX_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode_rx,
  input  logic [1:0]        cfg_poly_sel,
  input  logic [CRC_W-1:0]  cfg_init,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sob,
  input  logic              in_eob,
  output logic [CRC_W-1:0]  crc_out,
  output logic              res_valid,
  output logic              res_ok
);

  logic             rst_n_sync;
  logic             ready_q;
  logic [CRC_W-1:0] rem_q,  rem_d;
  poly_sel_e        sel_q,  sel_d;
  logic             rx_q,   rx_d;
  logic             rv_q,   rv_d;
  logic             ok_q,   ok_d;
  logic             accept, take_cfg;
  logic [CRC_W-1:0] seed;
  logic [CRC_W-1:0] taps, msb_mask, width_mask, step_out;

  blk_crc_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // Next-state logic
  always_comb begin
    accept   = in_valid & ready_q;
    take_cfg = accept & in_sob;
    sel_d    = take_cfg ? poly_sel_e'(cfg_poly_sel) : sel_q;
    rx_d     = take_cfg ? cfg_mode_rx : rx_q;
    seed     = in_sob ? cfg_init : rem_q;
  end

  blk_crc_poly_table #(.CRC_W(CRC_W)) poly_i (
    .sel        (sel_d),
    .taps       (taps),
    .msb_mask   (msb_mask),
    .width_mask (width_mask)
  );

  blk_crc_byte_step #(.DATA_W(DATA_W), .CRC_W(CRC_W)) step_i (
    .rem_in     (seed),
    .data       (in_data),
    .taps       (taps),
    .msb_mask   (msb_mask),
    .width_mask (width_mask),
    .rem_out    (step_out)
  );

  always_comb begin
    rem_d = step_out;
    rv_d  = accept & in_eob;
    ok_d  = accept & in_eob & rx_d & (step_out == '0);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ready_q <= 1'b0;
      rem_q   <= '0;
      sel_q   <= POLY_W4;
      rx_q    <= 1'b0;
      rv_q    <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      rv_q    <= rv_d;
      ok_q    <= ok_d;
      if (accept) begin
        rem_q <= rem_d;
      end
      if (take_cfg) begin
        sel_q <= sel_d;
        rx_q  <= rx_d;
      end
    end
  end

  assign in_ready  = ready_q;
  assign crc_out   = rem_q;
  assign res_valid = rv_q;
  assign res_ok    = ok_q;

  // Assertions
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(crc_out)); // R3

  AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_ready && in_eob)); // R5

  AST_OK_ONLY_RX: assert property (@(posedge clk) disable iff (!rst_n)
    res_ok |-> (res_valid && rx_q)); // R5

  AST_OK_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok) |-> (crc_out == '0)); // R6

  AST_NARROW_4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == POLY_W4) |-> (crc_out[CRC_W-1:4] == '0)); // R7

  AST_NARROW_8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == POLY_W8) |-> (crc_out[CRC_W-1:8] == '0)); // R7

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_sob) |=> ($stable(sel_q) && $stable(rx_q))); // R8

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready); // R9

endmodule

// File: tb/blk_crc_unit_tb_top.sv
module blk_crc_unit_tb_top;

  typedef logic [7:0] byte_q_t[$];

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_mode_rx;
  logic [1:0]  cfg_poly_sel;
  logic [15:0] cfg_init;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        in_sob;
  logic        in_eob;
  logic [15:0] crc_out;
  logic        res_valid;
  logic        res_ok;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // model state
  int          m_sel  = 0;
  bit          m_rx   = 0;
  logic [15:0] m_init = '0;
  byte_q_t     m_q;
  logic [15:0] m_rem  = '0;
  bit          m_rv   = 0;
  bit          m_ok   = 0;

  always #5 clk = ~clk;

  blk_crc_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode_rx  (cfg_mode_rx),
    .cfg_poly_sel (cfg_poly_sel),
    .cfg_init     (cfg_init),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_sob       (in_sob),
    .in_eob       (in_eob),
    .crc_out      (crc_out),
    .res_valid    (res_valid),
    .res_ok       (res_ok)
  );

  function automatic int width_of(input int sel);
    case (sel)
      0:       return 4;
      1:       return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [16:0] gen_of(input int sel);
    case (sel)
      0:       return 17'h00013;
      1:       return 17'h0011D;
      2:       return 17'h18005;
      default: return 17'h11021;
    endcase
  endfunction

  // Long division over the whole block, init folded into the leading W bits
  function automatic logic [15:0] model_rem(input byte_q_t msg, input logic [15:0] init,
                                            input int sel);
    int          w  = width_of(sel);
    logic [16:0] g  = gen_of(sel);
    bit          dv[$];
    logic [15:0] r  = '0;
    foreach (msg[i]) for (int b = 7; b >= 0; b--) dv.push_back(msg[i][b]);
    for (int j = 0; j < w; j++) dv.push_back(1'b0);
    for (int j = 0; j < w; j++) dv[j] = dv[j] ^ init[w-1-j];
    for (int i = 0; i < dv.size() - w; i++) begin
      if (dv[i]) begin
        for (int k = 0; k <= w; k++) dv[i+k] = dv[i+k] ^ g[w-k];
      end
    end
    for (int j = 0; j < w; j++) r[w-1-j] = dv[dv.size()-w+j];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 crc_out vs model", {16'h0, crc_out}, {16'h0, m_rem});
    chk("R5 res_valid vs model", {31'h0, res_valid}, {31'h0, m_rv});
    chk("R6 res_ok vs model", {31'h0, res_ok}, {31'h0, m_ok});
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cycle(input bit v, input logic [7:0] d, input bit s, input bit e);
    bit acc;
    compare_all();
    in_valid = v; in_data = d; in_sob = s; in_eob = e;
    acc = v && in_ready;
    @(posedge clk);
    if (acc) begin
      if (s) begin
        m_sel  = int'(cfg_poly_sel);
        m_rx   = cfg_mode_rx;
        m_init = cfg_init;
        m_q.delete();
      end
      m_q.push_back(d);
      m_rem = model_rem(m_q, m_init, m_sel);
    end
    m_rv = acc && e;
    m_ok = m_rv && m_rx && (m_rem == 16'h0);
    @(negedge clk);
    in_valid = 1'b0; in_sob = 1'b0; in_eob = 1'b0;
  endtask

  task automatic send(input byte_q_t blk, input bit gaps, input bit cfg_flip, input int sel);
    for (int i = 0; i < blk.size(); i++) begin
      if (gaps && ($urandom % 4 == 0)) cycle(1'b0, 8'h00, 1'b0, 1'b0);
      cycle(1'b1, blk[i], i == 0, i == blk.size() - 1);
      if (cfg_flip && i == 0) begin
        cfg_poly_sel = 2'((sel + 1) % 4);
        cfg_mode_rx  = ~cfg_mode_rx;
        cfg_init     = ~cfg_init;
      end
    end
  endtask

  // err: 0 none, 1 single bit, 2 burst of three adjacent bits
  task automatic run_pair(input int sel, input logic [15:0] init, input int len,
                          input int err, input bit flip);
    byte_q_t     d;
    byte_q_t     rx_blk;
    logic [15:0] crc;
    int          w = width_of(sel);
    int          pos;
    for (int i = 0; i < len; i++) d.push_back(8'($urandom));
    cfg_mode_rx = 1'b0; cfg_poly_sel = 2'(sel); cfg_init = init;
    send(d, 1'b1, 1'b0, sel);
    chk("R5 tx result pulse", {31'h0, res_valid}, 32'h1);
    chk("R5 tx res_ok low", {31'h0, res_ok}, 32'h0);
    chk("R7 tx width mask", {16'h0, crc_out >> w}, 32'h0);
    crc = m_rem;
    cycle(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R5 tx pulse one cycle", {31'h0, res_valid}, 32'h0);
    rx_blk = d;
    if (w == 16) begin
      rx_blk.push_back(crc[15:8]); rx_blk.push_back(crc[7:0]);
    end else if (w == 8) begin
      rx_blk.push_back(crc[7:0]);
    end else begin
      rx_blk.push_back({crc[3:0], 4'h0});
    end
    pos = $urandom % rx_blk.size();
    if (err == 1) rx_blk[pos] = rx_blk[pos] ^ (8'h01 << ($urandom % 8));
    if (err == 2) rx_blk[pos] = rx_blk[pos] ^ 8'h0E;
    cfg_mode_rx = 1'b1; cfg_poly_sel = 2'(sel); cfg_init = init;
    send(rx_blk, 1'b1, flip, sel);
    chk("R6 rx result pulse", {31'h0, res_valid}, 32'h1);
    if (flip) chk("R8 mid-block config change ignored", {31'h0, res_ok}, 32'h1);
    else      chk("R6 rx ok flag", {31'h0, res_ok}, {31'h0, (err == 0)});
    cycle(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int waited;
    byte_q_t one;
    logic [15:0] r1_exp [4] = '{16'h0003, 16'h001D, 16'h8005, 16'h1021};
    rst_n = 1'b0; cfg_mode_rx = 1'b0; cfg_poly_sel = 2'd0; cfg_init = '0;
    in_valid = 1'b0; in_data = '0; in_sob = 1'b0; in_eob = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 reset crc_out", {16'h0, crc_out}, 32'h0);
    chk("R4 reset res_valid", {31'h0, res_valid}, 32'h0);
    chk("R4 reset res_ok", {31'h0, res_ok}, 32'h0);
    chk("R9 ready low in reset", {31'h0, in_ready}, 32'h0);
    rst_n = 1'b1;
    waited = 0;
    while (!in_ready && waited < 8) begin
      @(negedge clk);
      waited++;
    end
    chk("R9 ready rises within four edges", {31'h0, (waited <= 4)}, 32'h1);
    chk("R9 ready high", {31'h0, in_ready}, 32'h1);

    // R1: known remainders of a single 0x01 byte
    for (int s = 0; s < 4; s++) begin
      one.delete(); one.push_back(8'h01);
      cfg_mode_rx = 1'b0; cfg_poly_sel = 2'(s); cfg_init = '0;
      send(one, 1'b0, 1'b0, s);
      chk("R1 polynomial remainder of 0x01", {16'h0, crc_out}, {16'h0, r1_exp[s]});
      cycle(1'b0, 8'h00, 1'b0, 1'b0);
    end

    // R4: block equal to the initial value leaves zero
    one.delete(); one.push_back(8'hAB); one.push_back(8'hCD);
    cfg_mode_rx = 1'b0; cfg_poly_sel = 2'd3; cfg_init = 16'hABCD;
    send(one, 1'b0, 1'b0, 3);
    chk("R4 init-equal block gives zero", {16'h0, crc_out}, 32'h0);
    cycle(1'b0, 8'h00, 1'b0, 1'b0);
    one.delete(); one.push_back(8'h5A);
    cfg_poly_sel = 2'd1; cfg_init = 16'h005A;
    send(one, 1'b0, 1'b0, 1);
    chk("R4 init-equal byte gives zero 8-bit", {16'h0, crc_out}, 32'h0);
    cycle(1'b0, 8'h00, 1'b0, 1'b0);

    // R3: idle cycles hold the remainder
    repeat (3) cycle(1'b0, 8'hFF, 1'b0, 1'b0);
    chk("R3 idle hold", {16'h0, crc_out}, 32'h0);

    for (int s = 0; s < 4; s++) begin
      run_pair(s, 16'h0000, 1, 0, 1'b0);
      run_pair(s, 16'h0000, 1 + ($urandom % 12), 0, 1'b0);
      run_pair(s, 16'($urandom), 1 + ($urandom % 12), 0, 1'b0);
      run_pair(s, 16'($urandom), 2 + ($urandom % 12), 1, 1'b0);
      run_pair(s, 16'hFFFF, 2 + ($urandom % 12), 2, 1'b0);
      run_pair(s, 16'($urandom), 3 + ($urandom % 8), 0, 1'b1);
    end

    cycle(1'b0, 8'h00, 1'b0, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule